// File: doc/BRIEF.md
# Prioritized Memory Transaction Queue

This block sits between request sources and a memory controller's per-bank command stage. It takes in transactions of three kinds: instruction fetches, data reads and data writes. Each carries an address and an ID. It holds them in an age-ordered store and hands one at a time to the downstream stage. The choice is made out of order, but only among the oldest `WIN` held entries. Fetches go before reads, and reads go before writes. Among entries of equal rank, the oldest wins.

Two rules gate eligibility. First, an entry whose bank queue reports full sits out that cycle, so traffic to other banks still flows. Second, an entry with an older entry to the same cache line still held is never issued, so same-line order is kept. A write that has waited `AGE_LIM` cycles is raised above all other classes, so writes cannot starve. Both sides use valid/ready handshakes, and a push and a pop may fall in the same cycle.

Top module: `txn_prio_queue`

## Requirements
- R1: Among eligible window entries, a fetch (class code 2'd0) is issued before a read (class code 2'd1).
- R2: A read is issued before a write (class code 2'd2; input code 2'd3 is treated as a write), and a fetch before a write. The output class is never 2'd3.
- R3: Only the `WIN` oldest held entries may be selected; a higher-priority entry beyond them waits.
- R4: An entry is not issued while an older held entry targets the same cache line.
- R5: An entry whose bank, `addr[BANK_LSB +: log2(NBANK)]`, has its `bank_full` bit set is ineligible that cycle, and other entries may still issue.
- R6: `out_valid` is high exactly when at least one window entry is eligible; it is low when the queue is empty.
- R7: Among eligible entries of equal rank, the oldest is selected.
- R8: `in_ready` is low exactly when `DEPTH` entries are held, and a push offered while full is dropped.
- R9: A write that has been held for at least `AGE_LIM` clock edges since acceptance outranks fetches and reads. Among several such writes, the oldest wins.
- R10: A push and a pop in the same cycle both take effect. The remaining entries keep their relative age order.
- R11: Same-line comparison ignores the low `LINE_LSB` address bits, so addresses that differ only in the byte offset within a line conflict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming transaction present |
| in_ready | output | 1 | Queue can accept a transaction |
| in_class | input | 2 | 0 fetch, 1 read, 2 or 3 write |
| in_addr | input | ADDR_W | Byte address |
| in_id | input | ID_W | Transaction ID |
| out_valid | output | 1 | A selected transaction is offered |
| out_ready | input | 1 | Downstream stage takes the offered transaction |
| out_class | output | 2 | Class of the offered transaction |
| out_addr | output | ADDR_W | Address of the offered transaction |
| out_id | output | ID_W | ID of the offered transaction |
| bank_full | input | NBANK | Per-bank downstream queue full flags |

## Verification
Directed sequences cover the following cases:
- Mixed classes pushed in reverse priority order, which separates class ranking from plain age order.
- Two same-class entries, which separate oldest-first from youngest-first.
- A high-priority fetch placed just beyond the window, which shows whether the window bound is honoured.
- A write and a later read to the same line, with the write's bank full, which shows whether the hazard holds the read back rather than letting it bypass.
- A read held against a waiting write over many idle cycles, which pins down when the write is promoted.
- A fill to capacity with an extra push, and a simultaneous push and pop, which check the occupancy rules.

A long seeded random run then covers the rest. It uses a small set of lines with random byte offsets and random bank-full flags and output stalls. It compares each cycle against a bench-side model of the queue.

// File: rtl/txq_pkg.sv
// Package txq_pkg: shared transaction class codes and the ranking function
// used by the priority selector. Lower rank value means higher priority.
package txq_pkg;

    typedef enum logic [1:0] {
        CLS_FETCH = 2'd0,
        CLS_READ  = 2'd1,
        CLS_WRITE = 2'd2
    } txn_class_e;

    // Map a class and its promotion flag to a 2-bit rank (0 = most urgent).
    function automatic logic [1:0] class_rank(input txn_class_e cls, input logic urgent);
        logic [1:0] r;
        case (cls)
            CLS_FETCH: r = 2'd1;
            CLS_READ:  r = 2'd2;
            default:   r = urgent ? 2'd0 : 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/txq_store.sv
// Module txq_store: age-ordered entry storage. Slot 0 is always the oldest
// entry. A pop removes one slot and shifts the younger slots down by one; a
// push lands just above the surviving entries. Each entry has a saturating
// age counter. Assumes the caller never pushes when cnt == DEPTH and never
// pops an index at or above cnt.
module txq_store
    import txq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int WIN     = 4,
    parameter int ADDR_W  = 32,
    parameter int ID_W    = 4,
    parameter int AGE_LIM = 16,
    parameter int AGE_W   = 5,
    parameter int CNT_W   = 4,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  txn_class_e        push_cls,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [ID_W-1:0]   push_id,
    input  logic              pop,
    input  logic [IDX_W-1:0]  pop_idx,
    output txn_class_e        cls_q  [DEPTH],
    output logic [ADDR_W-1:0] addr_q [DEPTH],
    output logic [ID_W-1:0]   id_q   [DEPTH],
    output logic [AGE_W-1:0]  age_win[WIN],
    output logic [CNT_W-1:0]  cnt
);

    logic [AGE_W-1:0]  age_q  [DEPTH];
    txn_class_e        cls_n  [DEPTH];
    logic [ADDR_W-1:0] addr_n [DEPTH];
    logic [ID_W-1:0]   id_n   [DEPTH];
    logic [AGE_W-1:0]  age_n  [DEPTH];
    logic [CNT_W-1:0]  keep;
    logic [CNT_W-1:0]  cnt_n;

    // Next-state: compact out the popped slot, age survivors, append the push.
    always_comb begin
        keep = cnt - CNT_W'(pop);
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = i;
            if (pop && (i >= int'(pop_idx)) && (i < DEPTH - 1)) begin
                src = i + 1;
            end
            cls_n[i]  = cls_q[src];
            addr_n[i] = addr_q[src];
            id_n[i]   = id_q[src];
            age_n[i]  = (age_q[src] >= AGE_W'(AGE_LIM)) ? age_q[src] : age_q[src] + 1'b1;
            if (push && (i == int'(keep))) begin
                cls_n[i]  = push_cls;
                addr_n[i] = push_addr;
                id_n[i]   = push_id;
                age_n[i]  = '0;
            end
        end
        cnt_n = keep + CNT_W'(push);
    end

    // Register the entry array and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                cls_q[i]  <= CLS_FETCH;
                addr_q[i] <= '0;
                id_q[i]   <= '0;
                age_q[i]  <= '0;
            end
        end else begin
            cnt <= cnt_n;
            for (int i = 0; i < DEPTH; i++) begin
                cls_q[i]  <= cls_n[i];
                addr_q[i] <= addr_n[i];
                id_q[i]   <= id_n[i];
                age_q[i]  <= age_n[i];
            end
        end
    end

    // Expose only the ages of the window slots to the selector.
    for (genvar g = 0; g < WIN; g++) begin : g_age_win
        assign age_win[g] = age_q[g];
    end

endmodule

// File: rtl/txq_elig.sv
// Module txq_elig: per-slot eligibility for the decode window. A slot is
// eligible when it is occupied, its bank is not full, and no older slot holds
// the same cache line. Assumes slots are age ordered (slot 0 oldest) and that
// the bank field lies at or above the line offset bits.
module txq_elig #(
    parameter int WIN    = 4,
    parameter int LINE_W = 26,
    parameter int NBANK  = 4,
    parameter int BOFF   = 0,
    parameter int CNT_W  = 4
) (
    input  logic [LINE_W-1:0] line_w [WIN],
    input  logic [CNT_W-1:0]  cnt,
    input  logic [NBANK-1:0]  bank_full,
    output logic [WIN-1:0]    elig
);

    localparam int BANK_W = $clog2(NBANK);

    // Evaluate occupancy, bank backpressure and the same-line hazard per slot.
    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            logic haz;
            logic [BANK_W-1:0] bk;
            haz = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (line_w[j] == line_w[i]) haz = 1'b1;
            end
            bk = line_w[i][BOFF +: BANK_W];
            elig[i] = (i < int'(cnt)) && !bank_full[bk] && !haz;
        end
    end

endmodule

// File: rtl/txq_pick.sv
// Module txq_pick: chooses one eligible window slot. Lowest rank wins, and
// ties go to the lowest slot index (the oldest). A write whose age has
// reached AGE_LIM takes the most urgent rank. Purely combinational.
module txq_pick
    import txq_pkg::*;
#(
    parameter int WIN     = 4,
    parameter int AGE_LIM = 16,
    parameter int AGE_W   = 5,
    parameter int WIDX_W  = 2
) (
    input  txn_class_e        cls_w [WIN],
    input  logic [AGE_W-1:0]  age_w [WIN],
    input  logic [WIN-1:0]    elig,
    output logic              any,
    output logic [WIDX_W-1:0] sel
);

    // Scan from youngest to oldest so an equal rank further down replaces it.
    always_comb begin
        logic [1:0] best;
        best = 2'd3;
        any  = 1'b0;
        sel  = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            logic [1:0] r;
            r = class_rank(cls_w[i], age_w[i] >= AGE_W'(AGE_LIM));
            if (elig[i] && (!any || r <= best)) begin
                best = r;
                sel  = WIDX_W'(i);
                any  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/txn_prio_queue.sv
// Module txn_prio_queue: prioritized request queue in front of a memory
// controller. It stores up to DEPTH transactions in age order and offers one
// selected from the oldest WIN entries each cycle. The choice honours class
// priority, write aging, per-bank backpressure and same-line ordering.
// Assumes power-of-two NBANK, 2 <= WIN <= DEPTH, and BANK_LSB >= LINE_LSB.
module txn_prio_queue
    import txq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int WIN      = 4,
    parameter int ADDR_W   = 32,
    parameter int ID_W     = 4,
    parameter int NBANK    = 4,
    parameter int LINE_LSB = 6,
    parameter int BANK_LSB = 6,
    parameter int AGE_LIM  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_class,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ID_W-1:0]   in_id,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_class,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ID_W-1:0]   out_id,
    input  logic [NBANK-1:0]  bank_full
);

    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int WIDX_W = $clog2(WIN);
    localparam int AGE_W  = $clog2(AGE_LIM + 1);
    localparam int LINE_W = ADDR_W - LINE_LSB;
    localparam int BOFF   = BANK_LSB - LINE_LSB;

    txn_class_e        cls_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [AGE_W-1:0]  age_win[WIN];
    txn_class_e        cls_win[WIN];
    logic [LINE_W-1:0] line_win[WIN];
    logic [CNT_W-1:0]  cnt;
    logic [WIN-1:0]    elig;
    logic [WIDX_W-1:0] sel_w;
    logic [IDX_W-1:0]  sel;
    logic              any;
    logic              push;
    logic              pop;
    txn_class_e        push_cls;

    // Fold the spare class code onto write.
    always_comb begin
        case (in_class)
            2'd0:    push_cls = CLS_FETCH;
            2'd1:    push_cls = CLS_READ;
            default: push_cls = CLS_WRITE;
        endcase
    end

    assign in_ready = (cnt < CNT_W'(DEPTH));
    assign push     = in_valid && in_ready;
    assign pop      = any && out_ready;
    assign sel      = IDX_W'(sel_w);

    // Slice the window views used by eligibility and selection.
    for (genvar g = 0; g < WIN; g++) begin : g_win
        assign cls_win[g]  = cls_q[g];
        assign line_win[g] = addr_q[g][ADDR_W-1:LINE_LSB];
    end

    txq_store #(
        .DEPTH(DEPTH), .WIN(WIN), .ADDR_W(ADDR_W), .ID_W(ID_W),
        .AGE_LIM(AGE_LIM), .AGE_W(AGE_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_cls(push_cls), .push_addr(in_addr), .push_id(in_id),
        .pop(pop), .pop_idx(sel),
        .cls_q(cls_q), .addr_q(addr_q), .id_q(id_q), .age_win(age_win), .cnt(cnt)
    );

    txq_elig #(
        .WIN(WIN), .LINE_W(LINE_W), .NBANK(NBANK), .BOFF(BOFF), .CNT_W(CNT_W)
    ) u_elig (
        .line_w(line_win), .cnt(cnt), .bank_full(bank_full), .elig(elig)
    );

    txq_pick #(
        .WIN(WIN), .AGE_LIM(AGE_LIM), .AGE_W(AGE_W), .WIDX_W(WIDX_W)
    ) u_pick (
        .cls_w(cls_win), .age_w(age_win), .elig(elig), .any(any), .sel(sel_w)
    );

    assign out_valid = any;
    assign out_class = 2'(cls_q[sel]);
    assign out_addr  = addr_q[sel];
    assign out_id    = id_q[sel];

endmodule

// File: rtl/txq_chk.sv
// Module txq_chk: assertion checker bound to txn_prio_queue. It observes
// the handshake ports, the bank flags and the internal occupancy count.
module txq_chk #(
    parameter int DEPTH    = 8,
    parameter int ADDR_W   = 32,
    parameter int NBANK    = 4,
    parameter int BANK_LSB = 6,
    parameter int CNT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic              pop,
    input logic              in_ready,
    input logic              out_valid,
    input logic [1:0]        out_class,
    input logic [ADDR_W-1:0] out_addr,
    input logic [NBANK-1:0]  bank_full,
    input logic [CNT_W-1:0]  cnt
);

    localparam int BANK_W = $clog2(NBANK);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) <= DEPTH); // R8
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (int'(cnt) == DEPTH) |-> !in_ready); // R8
    AST_CNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((CNT_W+1)'(cnt) == (CNT_W+1)'($past(cnt)) + (CNT_W+1)'($past(push)) - (CNT_W+1)'($past(pop)))); // R10
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (cnt == '0) |-> !out_valid); // R6
    AST_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bank_full[out_addr[BANK_LSB +: BANK_W]]); // R5
    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_class != 2'd3)); // R2

endmodule

bind txn_prio_queue txq_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_LSB(BANK_LSB), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .in_ready(in_ready),
    .out_valid(out_valid), .out_class(out_class), .out_addr(out_addr),
    .bank_full(bank_full), .cnt(cnt)
);

// File: tb/txn_prio_queue_tb.sv
// Bench txn_prio_queue_tb: directed corner cases plus seeded random traffic,
// each cycle compared against a bench-side queue model built from the brief.
module txn_prio_queue_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8, WIN = 4, ADDR_W = 32, ID_W = 4, NBANK = 4;
    localparam int LINE_LSB = 6, BANK_LSB = 6, AGE_LIM = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [1:0] in_class = '0, out_class;
    logic [ADDR_W-1:0] in_addr = '0, out_addr;
    logic [ID_W-1:0] in_id = '0, out_id;
    logic [NBANK-1:0] bank_full = '0;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Bench model of the queue, slot 0 oldest.
    logic [1:0]        m_cls  [DEPTH];
    logic [ADDR_W-1:0] m_addr [DEPTH];
    logic [ID_W-1:0]   m_id   [DEPTH];
    int                m_age  [DEPTH];
    int                m_cnt = 0;
    int                n_pops = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_prio_queue #(
        .DEPTH(DEPTH), .WIN(WIN), .ADDR_W(ADDR_W), .ID_W(ID_W), .NBANK(NBANK),
        .LINE_LSB(LINE_LSB), .BANK_LSB(BANK_LSB), .AGE_LIM(AGE_LIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_addr(in_addr), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
        .out_addr(out_addr), .out_id(out_id), .bank_full(bank_full)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rank_of(input int k);
        if (m_cls[k] == 2'd0) return 1;
        if (m_cls[k] == 2'd1) return 2;
        return (m_age[k] >= AGE_LIM) ? 0 : 3;
    endfunction

    // Expected selection from the requirements.
    function automatic void model_pick(input logic [NBANK-1:0] bf, output bit v, output int s);
        int best;
        v = 0; s = 0; best = 9;
        for (int i = 0; i < WIN && i < m_cnt; i++) begin
            bit ok;
            ok = !bf[m_addr[i][BANK_LSB +: 2]];
            for (int j = 0; j < i; j++)
                if (m_addr[j][ADDR_W-1:LINE_LSB] == m_addr[i][ADDR_W-1:LINE_LSB]) ok = 0;
            if (ok && rank_of(i) < best) begin
                best = rank_of(i); s = i; v = 1;
            end
        end
    endfunction

    // One cycle: drive, compare with model, advance model.
    task automatic step(input bit iv, input logic [1:0] cls, input logic [ADDR_W-1:0] addr,
                        input logic [ID_W-1:0] id, input bit ordy, input logic [NBANK-1:0] bf);
        bit ev; int es; bit pu;
        @(negedge clk);
        in_valid = iv; in_class = cls; in_addr = addr; in_id = id;
        out_ready = ordy; bank_full = bf;
        #1;
        model_pick(bf, ev, es);
        chk(in_ready == (m_cnt < DEPTH), "R8 in_ready", in_ready, m_cnt < DEPTH);
        chk(out_valid == ev, "R6 out_valid", out_valid, ev);
        if (ev) begin
            chk(out_addr == m_addr[es], "R3 out_addr", out_addr, m_addr[es]);
            chk(out_id == m_id[es], "R7 out_id", out_id, m_id[es]);
            chk(out_class == m_cls[es], "R1 out_class", out_class, m_cls[es]);
        end
        pu = iv && (m_cnt < DEPTH);
        if (ev && ordy) begin
            n_pops++;
            for (int i = es; i < DEPTH - 1; i++) begin
                m_cls[i] = m_cls[i+1]; m_addr[i] = m_addr[i+1];
                m_id[i] = m_id[i+1]; m_age[i] = m_age[i+1];
            end
            m_cnt--;
        end
        for (int i = 0; i < m_cnt; i++) if (m_age[i] < AGE_LIM) m_age[i]++;
        if (pu) begin
            m_cls[m_cnt] = (cls == 2'd3) ? 2'd2 : cls;
            m_addr[m_cnt] = addr; m_id[m_cnt] = id; m_age[m_cnt] = 0;
            m_cnt++;
        end
    endtask

    task automatic push1(input logic [1:0] cls, input int line, input logic [ID_W-1:0] id);
        step(1, cls, ADDR_W'(line) << LINE_LSB, id, 0, '0);
    endtask

    task automatic idle(input logic [NBANK-1:0] bf);
        step(0, 2'd0, '0, '0, 0, bf);
    endtask

    task automatic drain();
        int guard = 0;
        while (m_cnt > 0 && guard < 100) begin
            step(0, 2'd0, '0, '0, 1, '0);
            guard++;
        end
        chk(m_cnt == 0, "R6 drain", m_cnt, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R6 reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);
        @(negedge clk); rst_n = 1'b1;

        // R1: fetch ahead of read ahead of write, pushed in reverse order.
        push1(2'd2, 1, 4'h1); push1(2'd1, 2, 4'h2); push1(2'd0, 3, 4'h3);
        idle('0);
        chk(out_id == 4'h3 && out_class == 2'd0, "R1 fetch first", out_id, 4'h3);
        step(0, 2'd0, '0, '0, 1, '0);
        idle('0);
        chk(out_id == 4'h2, "R2 read before write", out_id, 4'h2);
        drain();

        // R7: two reads, the older one wins.
        push1(2'd1, 10, 4'h5); push1(2'd1, 11, 4'h6); idle('0);
        chk(out_id == 4'h5, "R7 oldest of class", out_id, 4'h5);
        drain();

        // R3: fetch beyond the window waits behind four writes.
        for (int k = 0; k < WIN; k++) push1(2'd2, 16 + k, ID_W'(k));
        push1(2'd0, 20, 4'hF); idle('0);
        chk(out_id == 4'h0 && out_class == 2'd2, "R3 window bound", out_id, 0);
        drain();

        // R4 and R11: read to the same line (other offset) behind a write to a full bank.
        step(1, 2'd2, 32'h0000_1080, 4'h7, 0, '0);
        step(1, 2'd1, 32'h0000_10B8, 4'h8, 0, '0);
        idle(4'b0100);
        chk(out_valid == 1'b0, "R4 R11 hazard blocks read", out_valid, 0);
        idle('0);
        chk(out_id == 4'h7, "R4 older write goes first", out_id, 4'h7);
        drain();

        // R5: bank 0 full, the bank 1 read proceeds.
        push1(2'd0, 8, 4'h1); push1(2'd1, 9, 4'h2); idle(4'b0001);
        chk(out_id == 4'h2, "R5 other bank proceeds", out_id, 4'h2);
        drain();

        // R9: a waiting write overtakes a read after AGE_LIM cycles.
        push1(2'd3, 24, 4'hA); push1(2'd1, 25, 4'hB); idle('0);
        chk(out_id == 4'hB, "R9 read before young write", out_id, 4'hB);
        repeat (AGE_LIM + 2) idle('0);
        chk(out_id == 4'hA && out_class == 2'd2, "R9 aged write promoted", out_id, 4'hA);
        drain();

        // R8: fill, push while full is dropped.
        for (int k = 0; k < DEPTH; k++) push1(2'd1, 32 + k, ID_W'(k));
        idle('0);
        chk(in_ready == 1'b0, "R8 full", in_ready, 0);
        push1(2'd0, 40, 4'hE);
        n_pops = 0;
        drain();
        chk(n_pops == DEPTH, "R8 dropped push", n_pops, DEPTH);

        // R10: push and pop in one cycle.
        push1(2'd0, 41, 4'h3);
        step(1, 2'd1, ADDR_W'(42) << LINE_LSB, 4'h4, 1, '0);
        idle('0);
        chk(out_valid && out_id == 4'h4, "R10 push with pop", out_id, 4'h4);
        step(0, 2'd0, '0, '0, 1, '0);
        idle('0);
        chk(out_valid == 1'b0, "R10 single entry left", out_valid, 0);

        // Random traffic over a small set of lines with random offsets.
        for (int n = 0; n < 4000; n++) begin
            logic [ADDR_W-1:0] a;
            a = (ADDR_W'($urandom % 12) << LINE_LSB) | ADDR_W'($urandom % 64);
            step(($urandom % 3) != 0, 2'($urandom % 4), a, ID_W'($urandom),
                 ($urandom % 3) != 0, (($urandom % 4) == 0) ? NBANK'($urandom) : '0);
        end
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule